// File: doc/BRIEF.md
# PWM Compare Shadow-Update Controller

This block sits between a host write port and the comparator of a PWM stage. It holds six double-buffered registers: four compare values (RA, RB, SA, SB), an output-routing word and an output-configuration word. Each register has a shadow copy that the host writes and an active copy that drives the comparator. The block decides when shadow values move into the active copies, so that a host can rewrite a whole set of compare values without the running PWM cycle seeing a half-updated set.

Two hold controls set the transfer policy. A manual hold freezes the active copies until the host clears it. An automatic hold moves the whole set at the end of a PWM cycle, but only when RB was the last shadow register written, and it takes precedence over the manual hold. With neither hold set, writes go straight through. A small period counter (period = active RB) with a one-clock end-of-cycle pulse and a simple two-output stage with polarity and routing control are included so the update policy can be observed at the ports.

Top module: `pwm_shd_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every shadow and active register, both hold controls, the last-written flag and the counter; after reset the first register write goes straight to the active copy.
- R2: With both holds clear, a write to selector 0..5 (0=RA, 1=RB, 2=SA, 3=SB, 4=routing word, 5=configuration word) appears on the matching active output on the clock after the write edge.
- R3: Selector 6 writes the hold controls (bit 0 manual hold, bit 1 automatic hold); a write to selector 7 changes no register.
- R4: While either hold is set, writes change only shadow copies; the active outputs stay unchanged except at a transfer defined by R5, R6 or R7.
- R5: When a control write clears a set manual hold and leaves the automatic hold clear, all six shadow values are copied to the active registers exactly once, on the clock edge after the control write edge.
- R6: With the automatic hold set, all six shadow values are copied at a clock where the end-of-cycle pulse is high and the last-written flag is set; a write to RB sets the flag, a write to any other shadow register clears it, and a copy clears it.
- R7: With both holds set, transfers follow R6 only; clearing the manual hold while the automatic hold stays set causes no transfer.
- R8: While run is high the counter advances by one per clock and wraps to 0 after the clock in which it equals active RB; cyc_end is high exactly in that clock; while run is low the counter holds and cyc_end is low.
- R9: Configuration word fields: bits 1:0 are the waveform mode (00 one-ramp, 01 two-ramp, 10 four-ramp, 11 centre-aligned), bit 2 is polarity, bit 3 is routing enable; the word is buffered like the compare registers.
- R10: Internal level A is high when SA <= cnt < RA; level B is high when cnt >= SB (active values).
- R11: With routing disabled, polarity 0 drives out_a/out_b as the inverse of levels A/B (active-low); polarity 1 drives them equal to the levels.
- R12: With routing enabled, with k = 2*A + B, out_a = routing bit k and out_b = routing bit 4+k; polarity has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (0..5 registers, 6 hold controls, 7 none) |
| wr_data | input | DW | Write data |
| run | input | 1 | Counter enable |
| cnt | output | DW | Period counter value |
| cyc_end | output | 1 | End-of-cycle pulse |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| act_ra | output | DW | Active RA compare |
| act_rb | output | DW | Active RB compare (period) |
| act_sa | output | DW | Active SA compare |
| act_sb | output | DW | Active SB compare |
| act_mtx | output | DW | Active routing word |
| act_cfg | output | DW | Active configuration word |

## Verification
The transfer properties assume that no register write lands on the same clock as a release or an automatic transfer, because the write would then win over the copied value for its own register; the bench keeps writes and cycle ends apart by holding run low whenever it writes. The properties also assume DW is at least 8 so the routing word is whole, and the bench only uses the default width. Period values stay small so each cycle end is reached within a few clocks.

// File: rtl/pwm_shd_pkg.sv
package pwm_shd_pkg;

  localparam int SEL_W = 3;
  localparam int NREG  = 6;
  localparam int MTX_W = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_RA   = 3'd0,
    SEL_RB   = 3'd1,
    SEL_SA   = 3'd2,
    SEL_SB   = 3'd3,
    SEL_MTX  = 3'd4,
    SEL_CFG  = 3'd5,
    SEL_CTRL = 3'd6,
    SEL_NONE = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    MODE_ONE_RAMP  = 2'b00,
    MODE_TWO_RAMP  = 2'b01,
    MODE_FOUR_RAMP = 2'b10,
    MODE_CENTRE    = 2'b11
  } mode_e;

  localparam int CFG_MODE_LO = 0;
  localparam int CFG_POL     = 2;
  localparam int CFG_MEN     = 3;

  localparam int CTRL_MAN  = 0;
  localparam int CTRL_AUTO = 1;

endpackage

// File: rtl/pwm_shd_regbank.sv
module pwm_shd_regbank
  import pwm_shd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [DW-1:0]             wr_data,
  input  logic                      direct,
  input  logic                      xfer,
  output logic [NREG-1:0][DW-1:0]   shd_vec,
  output logic [NREG-1:0][DW-1:0]   act_vec
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_vec[i] <= '0;
      end else if (hit) begin
        shd_vec[i] <= wr_data;
      end
    end

    // a write that passes straight through wins over a bulk copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_vec[i] <= '0;
      end else if (hit && direct) begin
        act_vec[i] <= wr_data;
      end else if (xfer) begin
        act_vec[i] <= shd_vec[i];
      end
    end
  end

endmodule

// File: rtl/pwm_shd_policy.sv
module pwm_shd_policy
  import pwm_shd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [1:0]       ctrl_bits,
  input  logic             cyc_end,
  output logic             lock_man,
  output logic             lock_auto,
  output logic             rb_last,
  output logic             direct,
  output logic             xfer_auto,
  output logic             xfer_rel,
  output logic             xfer
);

  logic wr_ctrl;
  logic wr_shadow;
  logic wr_rb;
  logic rel_pend;

  assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
  assign wr_shadow = wr_en && (wr_sel < SEL_W'(NREG));
  assign wr_rb     = wr_en && (wr_sel == SEL_RB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_man  <= 1'b0;
      lock_auto <= 1'b0;
    end else if (wr_ctrl) begin
      lock_man  <= ctrl_bits[CTRL_MAN];
      lock_auto <= ctrl_bits[CTRL_AUTO];
    end
  end

  // one-clock marker: a set manual hold has just been cleared
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_pend <= 1'b0;
    end else begin
      rel_pend <= wr_ctrl && lock_man && !ctrl_bits[CTRL_MAN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_last <= 1'b0;
    end else if (wr_shadow) begin
      rb_last <= wr_rb;
    end else if (xfer_auto) begin
      rb_last <= 1'b0;
    end
  end

  assign direct    = !lock_man && !lock_auto;
  assign xfer_auto = lock_auto && cyc_end && rb_last;
  assign xfer_rel  = rel_pend && !lock_auto;
  assign xfer      = xfer_auto || xfer_rel;

endmodule

// File: rtl/pwm_shd_cycle.sv
module pwm_shd_cycle #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] per,
  input  logic [DW-1:0] ra,
  input  logic [DW-1:0] sa,
  input  logic [DW-1:0] sb,
  output logic [DW-1:0] cnt,
  output logic          cyc_end,
  output logic          raw_a,
  output logic          raw_b
);

  function automatic logic [DW-1:0] f_next(input logic [DW-1:0] c,
                                           input logic [DW-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  function automatic logic f_window(input logic [DW-1:0] c,
                                    input logic [DW-1:0] lo,
                                    input logic [DW-1:0] hi);
    return (c >= lo) && (c < hi);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= f_next(cnt, per);
    end
  end

  assign cyc_end = run && (cnt == per);
  assign raw_a   = f_window(cnt, sa, ra);
  assign raw_b   = (cnt >= sb);

endmodule

// File: rtl/pwm_shd_drive.sv
module pwm_shd_drive
  import pwm_shd_pkg::*;
(
  input  logic             raw_a,
  input  logic             raw_b,
  input  logic             pol,
  input  logic             men,
  input  logic [MTX_W-1:0] mtx,
  output logic             out_a,
  output logic             out_b
);

  // returns {b, a}
  function automatic logic [1:0] f_route(input logic a, input logic b,
                                         input logic p, input logic m_en,
                                         input logic [MTX_W-1:0] m);
    logic [1:0] k;
    k = {a, b};
    if (m_en) begin
      return {m[{1'b1, k}], m[{1'b0, k}]};
    end
    return p ? {b, a} : {~b, ~a};
  endfunction

  logic [1:0] drv;
  assign drv   = f_route(raw_a, raw_b, pol, men, mtx);
  assign out_a = drv[0];
  assign out_b = drv[1];

endmodule

// File: rtl/pwm_shd_ctrl.sv
module pwm_shd_ctrl
  import pwm_shd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             run,
  output logic [DW-1:0]    cnt,
  output logic             cyc_end,
  output logic             out_a,
  output logic             out_b,
  output logic [DW-1:0]    act_ra,
  output logic [DW-1:0]    act_rb,
  output logic [DW-1:0]    act_sa,
  output logic [DW-1:0]    act_sb,
  output logic [DW-1:0]    act_mtx,
  output logic [DW-1:0]    act_cfg
);

  logic [NREG-1:0][DW-1:0] shd_vec;
  logic [NREG-1:0][DW-1:0] act_vec;
  logic lock_man;
  logic lock_auto;
  logic rb_last;
  logic direct;
  logic xfer_auto;
  logic xfer_rel;
  logic xfer;
  logic raw_a;
  logic raw_b;
  logic pol;
  logic men;
  logic [MTX_W-1:0] mtx;

  pwm_shd_policy u_policy (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .ctrl_bits (wr_data[1:0]),
    .cyc_end   (cyc_end),
    .lock_man  (lock_man),
    .lock_auto (lock_auto),
    .rb_last   (rb_last),
    .direct    (direct),
    .xfer_auto (xfer_auto),
    .xfer_rel  (xfer_rel),
    .xfer      (xfer)
  );

  pwm_shd_regbank #(.DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .direct  (direct),
    .xfer    (xfer),
    .shd_vec (shd_vec),
    .act_vec (act_vec)
  );

  pwm_shd_cycle #(.DW(DW)) u_cycle (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .per     (act_vec[SEL_RB]),
    .ra      (act_vec[SEL_RA]),
    .sa      (act_vec[SEL_SA]),
    .sb      (act_vec[SEL_SB]),
    .cnt     (cnt),
    .cyc_end (cyc_end),
    .raw_a   (raw_a),
    .raw_b   (raw_b)
  );

  assign pol = act_vec[SEL_CFG][CFG_POL];
  assign men = act_vec[SEL_CFG][CFG_MEN];
  assign mtx = act_vec[SEL_MTX][MTX_W-1:0];

  pwm_shd_drive u_drive (
    .raw_a (raw_a),
    .raw_b (raw_b),
    .pol   (pol),
    .men   (men),
    .mtx   (mtx),
    .out_a (out_a),
    .out_b (out_b)
  );

  assign act_ra  = act_vec[SEL_RA];
  assign act_rb  = act_vec[SEL_RB];
  assign act_sa  = act_vec[SEL_SA];
  assign act_sb  = act_vec[SEL_SB];
  assign act_mtx = act_vec[SEL_MTX];
  assign act_cfg = act_vec[SEL_CFG];

endmodule

// File: rtl/pwm_shd_chk.sv
module pwm_shd_chk
  import pwm_shd_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [SEL_W-1:0]        wr_sel,
  input logic [DW-1:0]           wr_data,
  input logic                    run,
  input logic                    lock_man,
  input logic                    lock_auto,
  input logic                    rb_last,
  input logic                    cyc_end,
  input logic [DW-1:0]           cnt,
  input logic [NREG-1:0][DW-1:0] shd_vec,
  input logic [NREG-1:0][DW-1:0] act_vec,
  input logic                    raw_a,
  input logic                    raw_b,
  input logic                    pol,
  input logic                    men,
  input logic [MTX_W-1:0]        mtx,
  input logic                    out_a,
  input logic                    out_b
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (act_vec == '0) && (shd_vec == '0) && !lock_man && !lock_auto && (cnt == '0));

  for (genvar i = 0; i < NREG; i++) begin : g_direct
    p_direct_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_sel == SEL_W'(i)) && !lock_man && !lock_auto
      |=> act_vec[i] == $past(wr_data));
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_man || lock_auto) && !(lock_auto && cyc_end && rb_last) |=> $stable(act_vec));

  p_release_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_man) && !lock_auto && !wr_en |=> act_vec == $past(shd_vec));

  p_auto_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_auto && cyc_end && rb_last && !wr_en |=> (act_vec == $past(shd_vec)) && !rb_last);

  p_rb_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == SEL_RB) |=> rb_last);

  p_rb_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel < SEL_W'(NREG)) && (wr_sel != SEL_RB) |=> !rb_last);

  p_auto_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_auto && !(cyc_end && rb_last) |=> $stable(act_vec));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> cnt == '0);

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cyc_end |=> cnt == DW'($past(cnt) + 1'b1));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  always_comb begin
    if (rst_n && !men) begin
      p_polarity_r11: assert ((out_a == (pol ? raw_a : !raw_a)) &&
                              (out_b == (pol ? raw_b : !raw_b)));
    end
    if (rst_n && men) begin
      p_routing_r12: assert ((out_a == mtx[{1'b0, raw_a, raw_b}]) &&
                             (out_b == mtx[{1'b1, raw_a, raw_b}]));
    end
  end

endmodule

bind pwm_shd_ctrl pwm_shd_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .run       (run),
  .lock_man  (lock_man),
  .lock_auto (lock_auto),
  .rb_last   (rb_last),
  .cyc_end   (cyc_end),
  .cnt       (cnt),
  .shd_vec   (shd_vec),
  .act_vec   (act_vec),
  .raw_a     (raw_a),
  .raw_b     (raw_b),
  .pol       (pol),
  .men       (men),
  .mtx       (mtx),
  .out_a     (out_a),
  .out_b     (out_b)
);

// File: tb/pwm_shd_ctrl_bench.sv
module pwm_shd_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       run = 1'b0;
  logic [7:0] cnt;
  logic       cyc_end;
  logic       out_a;
  logic       out_b;
  logic [7:0] act_ra, act_rb, act_sa, act_sb, act_mtx, act_cfg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_shd_ctrl u_pwm_shd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .cnt(cnt), .cyc_end(cyc_end), .out_a(out_a), .out_b(out_b),
    .act_ra(act_ra), .act_rb(act_rb), .act_sa(act_sa), .act_sb(act_sb),
    .act_mtx(act_mtx), .act_cfg(act_cfg)
  );

  // {write sel[3], write data[8], checked sel[3], expected active[8]}
  localparam logic [21:0] VEC [9] = '{
    {3'd0, 8'h12, 3'd0, 8'h12},
    {3'd1, 8'h34, 3'd1, 8'h34},
    {3'd2, 8'h56, 3'd2, 8'h56},
    {3'd3, 8'h78, 3'd3, 8'h78},
    {3'd4, 8'h9A, 3'd4, 8'h9A},
    {3'd5, 8'h0C, 3'd5, 8'h0C},
    {3'd7, 8'hFF, 3'd0, 8'h12},
    {3'd7, 8'hFF, 3'd5, 8'h0C},
    {3'd0, 8'h00, 3'd1, 8'h34}
  };

  function automatic logic [7:0] act_of(input logic [2:0] s);
    case (s)
      3'd0: return act_ra;
      3'd1: return act_rb;
      3'd2: return act_sa;
      3'd3: return act_sb;
      3'd4: return act_mtx;
      default: return act_cfg;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_end(input string req);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cyc_end) begin
        seen = 1'b1;
        break;
      end
    end
    chk(req, "cycle end reached", {31'd0, seen}, 32'd1);
    @(negedge clk);
  endtask

  // outputs expected from the written constants RB=7 SA=2 RA=5 SB=4 MTX=B4
  task automatic out_run(input logic [7:0] cfg, input string req);
    logic [7:0] prev;
    logic la, lb, ea, eb;
    logic [1:0] k;
    wr(3'd5, cfg);
    @(negedge clk);
    run = 1'b1;
    prev = cnt;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      chk("R8", "counter step", {24'd0, cnt}, {24'd0, (prev == 8'd7) ? 8'd0 : prev + 8'd1});
      chk("R8", "cycle end pulse", {31'd0, cyc_end}, {31'd0, cnt == 8'd7});
      la = (cnt >= 8'd2) && (cnt < 8'd5);
      lb = (cnt >= 8'd4);
      k = {la, lb};
      if (cfg[3]) begin
        ea = 8'hB4 >> k;
        eb = 8'hB4 >> (4 + k);
      end else begin
        ea = cfg[2] ? la : !la;
        eb = cfg[2] ? lb : !lb;
      end
      chk(req, "out_a (R10 levels)", {31'd0, out_a}, {31'd0, ea});
      chk(req, "out_b (R10 levels)", {31'd0, out_b}, {31'd0, eb});
      prev = cnt;
    end
    run = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state; R11 active-low idle outputs with cnt=0
    chk("R1", "act_ra", {24'd0, act_ra}, 0);
    chk("R1", "act_rb", {24'd0, act_rb}, 0);
    chk("R1", "act_cfg", {24'd0, act_cfg}, 0);
    chk("R1", "cnt", {24'd0, cnt}, 0);
    chk("R8", "no cycle end while idle", {31'd0, cyc_end}, 0);
    chk("R11", "out_a at reset", {31'd0, out_a}, 1);
    chk("R11", "out_b at reset", {31'd0, out_b}, 0);

    // vector walk: R2 direct writes and R3 ignored selector
    for (int v = 0; v < 9; v++) begin
      wr(VEC[v][21:19], VEC[v][18:11]);
      chk((VEC[v][21:19] == 3'd7) ? "R3" : "R2", "vector active value",
          {24'd0, act_of(VEC[v][10:8])}, {24'd0, VEC[v][7:0]});
    end

    // R4 / R5 / R9 manual hold and release
    wr(3'd0, 8'h02);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h01);
    wr(3'd0, 8'h40);
    wr(3'd3, 8'h11);
    wr(3'd4, 8'h5A);
    wr(3'd5, 8'h03);
    chk("R4", "RA held", {24'd0, act_ra}, 32'h02);
    chk("R4", "routing held", {24'd0, act_mtx}, 32'h9A);
    chk("R9", "mode held", {24'd0, act_cfg}, 32'h00);
    wr(3'd6, 8'h00);
    chk("R5", "no copy on release edge", {24'd0, act_ra}, 32'h02);
    @(negedge clk);
    chk("R5", "RA copied", {24'd0, act_ra}, 32'h40);
    chk("R5", "SB copied", {24'd0, act_sb}, 32'h11);
    chk("R5", "routing copied", {24'd0, act_mtx}, 32'h5A);
    chk("R9", "mode centre-aligned", {30'd0, act_cfg[1:0]}, 32'd3);

    // R6 automatic hold
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h02);
    wr(3'd6, 8'h02);
    wr(3'd0, 8'h05);
    run = 1'b1;
    repeat (10) @(negedge clk);
    run = 1'b0;
    chk("R6", "no copy without RB last", {24'd0, act_ra}, 32'h02);
    wr(3'd1, 8'h04);
    chk("R6", "RB held before cycle end", {24'd0, act_rb}, 32'h03);
    run = 1'b1;
    wait_end("R6");
    run = 1'b0;
    chk("R6", "RA copied at cycle end", {24'd0, act_ra}, 32'h05);
    chk("R6", "RB copied at cycle end", {24'd0, act_rb}, 32'h04);

    // R7 both holds
    wr(3'd6, 8'h03);
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h06);
    run = 1'b1;
    wait_end("R7");
    run = 1'b0;
    chk("R7", "copy under both holds", {24'd0, act_ra}, 32'h09);
    chk("R7", "period under both holds", {24'd0, act_rb}, 32'h06);
    wr(3'd0, 8'h0A);
    wr(3'd6, 8'h02);
    repeat (3) @(negedge clk);
    chk("R7", "release ignored with auto hold", {24'd0, act_ra}, 32'h09);
    wr(3'd6, 8'h00);

    // R10 / R11 / R12 output stage with counter R8
    wr(3'd1, 8'h07);
    wr(3'd2, 8'h02);
    wr(3'd0, 8'h05);
    wr(3'd3, 8'h04);
    wr(3'd4, 8'hB4);
    out_run(8'h00, "R11");
    out_run(8'h04, "R11");
    out_run(8'h08, "R12");
    out_run(8'h0C, "R12");

    // R1 reset mid-operation clears hold
    wr(3'd6, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "RB after reset", {24'd0, act_rb}, 0);
    chk("R1", "routing after reset", {24'd0, act_mtx}, 0);
    rst_n = 1'b1;
    wr(3'd0, 8'h33);
    chk("R1", "hold cleared by reset", {24'd0, act_ra}, 32'h33);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule